// File: doc/BRIEF.md
# Digital Timekeeping Trim Unit

This block sits in the divider chain that turns a 32768 Hz oscillator enable into a 1 Hz time base. It trims the long-term rate of the clock without touching the oscillator. A 64-minute schedule picks a number of leading minutes, and in each of those minutes the first second is made shorter or longer by a fixed number of oscillator ticks. The change is made at the divide-by-256 stage. In the positive direction one 256-tick group is counted twice, so the clock speeds up. In the negative direction one group boundary is held back by half a group, so the clock slows down.

The trim word has a direction bit and a 5-bit magnitude. It is sampled once, on the first tick of every minute, so that rewriting it never disturbs a second already under way. The block also gives a minute strobe and a 512 Hz square wave taken straight from the raw tick enable. That wave lets the oscillator frequency be measured without any trimming mixed in.

Top module: `clkcal_trim`

## Requirements
- R1: While reset is low, `sec_tick`, `min_tick` and `ft_out` are 0. After reset the schedule starts at minute 0, second 0.
- R2: The block advances only on cycles with `tick_en` high. An unmodified second lasts POST_DIV*2^PRE_W ticks (1024 ticks in the bench configuration, 32768 by default).
- R3: A magnitude of 0 gives no modified second in any minute, whatever the direction bit.
- R4: With the direction bit at 1 and magnitude N, the first second of each of minutes 0 to 2N-1 of the cycle lasts 2^PRE_W ticks (256) fewer than normal.
- R5: With the direction bit at 0 and magnitude N, the first second of each of minutes 0 to 2N-1 lasts 2^(PRE_W-1) ticks (128) more than normal.
- R6: Only the first second of a minute can be modified. `min_tick` pulses together with the `sec_tick` that ends second SEC_PER_MIN-1 of the minute.
- R7: The minute index wraps from 63 back to 0. With the largest magnitude, minutes 62 and 63 stay unmodified and minute 0 of the next cycle is modified again.
- R8: The direction bit and the magnitude are sampled on the first tick of each minute. A change made during a minute takes effect only from the next minute.
- R9: `ft_out` is a square wave that toggles every 32 ticks (period 64 ticks, 512 Hz at 32768 Hz) and starts low after reset. The trim word does not affect it, and it holds while `tick_en` is low.
- R10: `sec_tick` and `min_tick` are single-cycle pulses, issued the cycle after the tick that ends the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle enable at the oscillator rate (32768 Hz) |
| cal_sign | input | 1 | Trim direction: 1 shortens seconds, 0 lengthens them |
| cal_mag | input | MAG_W | Trim magnitude, 0 means no trim |
| sec_tick | output | 1 | Corrected one-second pulse |
| min_tick | output | 1 | Pulse at the end of each minute |
| ft_out | output | 1 | Untrimmed 512 Hz test square wave |

## Verification
Second lengths are measured as cycle counts between successive second pulses, with the tick enable held high. Two zero-magnitude runs, one for each direction bit, establish the normal 1024-tick length and show that the direction bit alone changes nothing. Magnitudes 1 and 2 in each direction separate shortened from lengthened seconds. They also show that the modified-minute count ends exactly at 2N and that only the first second of a minute is touched. A magnitude-31 run across a full 64-minute wrap exposes off-by-one errors in the cycle limit. A tick enable that toggles every cycle shows that the divider counts ticks and not clocks. Rewriting the trim word in mid-minute shows when it is sampled, and the test wave is compared cycle by cycle across a stretched second.

// File: rtl/clkcal_pkg.sv
package clkcal_pkg;

   // correction applied to the second now running
   typedef enum logic [1:0] {
      CORR_NONE = 2'd0,
      CORR_FAST = 2'd1,
      CORR_SLOW = 2'd2
   } corr_e;

   // select a correction mode from the sampled trim word
   function automatic corr_e pick_mode(input logic hit, input logic dir);
      if (!hit)     return CORR_NONE;
      else if (dir) return CORR_FAST;
      else          return CORR_SLOW;
   endfunction

endpackage

// File: rtl/clkcal_prescale.sv
// Divide-by-2^PRE_W stage. On request it holds the first group boundary
// back by half a group.
module clkcal_prescale #(
   parameter int PRE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic lengthen,
   output logic wrap_evt,
   output logic carry
);
   localparam int ST_W = PRE_W - 1;
   localparam logic [PRE_W-1:0] PRE_MAX = '1;
   localparam logic [ST_W-1:0]  ST_MAX  = '1;

   if (PRE_W < 2) begin : g_bad_pre
      $error("clkcal_prescale: PRE_W must be at least 2");
   end

   logic [PRE_W-1:0] pre_cnt;
   logic [ST_W-1:0]  stall_cnt;
   logic             in_stall;
   logic             stall_done;

   assign wrap_evt   = tick && !in_stall && (pre_cnt == PRE_MAX);
   assign stall_done = tick && in_stall && (stall_cnt == ST_MAX);
   assign carry      = (wrap_evt && !lengthen) || stall_done;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_cnt   <= '0;
         stall_cnt <= '0;
         in_stall  <= 1'b0;
      end else if (tick) begin
         if (in_stall) begin
            if (stall_done) begin
               in_stall  <= 1'b0;
               stall_cnt <= '0;
               pre_cnt   <= '0;
            end else begin
               stall_cnt <= stall_cnt + 1'b1;
            end
         end else if (wrap_evt && lengthen) begin
            in_stall  <= 1'b1;
            stall_cnt <= '0;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/clkcal_secdiv.sv
// Counts prescaler carries into seconds. A skip request makes one carry count twice.
module clkcal_secdiv #(
   parameter int POST_DIV = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic carry,
   input  logic skip,
   output logic sec_end
);
   localparam int PD_W = $clog2(POST_DIV + 1);

   if (POST_DIV < 4) begin : g_bad_div
      $error("clkcal_secdiv: POST_DIV must be at least 4");
   end

   logic [PD_W-1:0] post_cnt;
   logic [PD_W:0]   nxt;

   assign nxt     = {1'b0, post_cnt} + ((PD_W+1)'(skip ? 2 : 1));
   assign sec_end = carry && (nxt >= (PD_W+1)'(POST_DIV));

   always_ff @(posedge clk) begin
      if (!rst_n)
         post_cnt <= '0;
      else if (carry)
         post_cnt <= sec_end ? '0 : nxt[PD_W-1:0];
   end
endmodule

// File: rtl/clkcal_schedule.sv
// Second, minute and 64-minute cycle position. Samples the trim word at each
// minute start and arms one correction for the first group of that minute.
module clkcal_schedule
   import clkcal_pkg::*;
#(
   parameter int SEC_PER_MIN = 60,
   parameter int CYC_MIN     = 64,
   parameter int MAG_W       = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             sec_end,
   input  logic             wrap_evt,
   input  logic             cal_sign,
   input  logic [MAG_W-1:0] cal_mag,
   output logic             min_end,
   output logic             fast_req,
   output logic             slow_req
);
   localparam int SEC_W = $clog2(SEC_PER_MIN);
   localparam int CYC_W = $clog2(CYC_MIN);

   if (SEC_PER_MIN < 2) begin : g_bad_sec
      $error("clkcal_schedule: SEC_PER_MIN must be at least 2");
   end
   if (CYC_MIN <= 2 * ((2 ** MAG_W) - 1)) begin : g_bad_cyc
      $error("clkcal_schedule: CYC_MIN too small for the largest magnitude");
   end

   logic [SEC_W-1:0] sec_cnt;
   logic [CYC_W-1:0] min_idx;
   logic             new_min;
   logic             hit;
   corr_e            mode_q;

   assign min_end  = sec_end && (sec_cnt == SEC_W'(SEC_PER_MIN - 1));
   assign hit      = (int'(min_idx) < 2 * int'(cal_mag));
   assign fast_req = (mode_q == CORR_FAST);
   assign slow_req = (mode_q == CORR_SLOW);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_cnt <= '0;
         min_idx <= '0;
         new_min <= 1'b1;
         mode_q  <= CORR_NONE;
      end else begin
         if (tick && new_min) begin
            mode_q  <= pick_mode(hit, cal_sign);
            new_min <= 1'b0;
         end else if (wrap_evt) begin
            mode_q <= CORR_NONE;
         end
         if (sec_end) begin
            if (min_end) begin
               sec_cnt <= '0;
               new_min <= 1'b1;
               min_idx <= (min_idx == CYC_W'(CYC_MIN - 1)) ? '0 : min_idx + 1'b1;
            end else begin
               sec_cnt <= sec_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/clkcal_ftgen.sv
// Free-running test-wave divider driven by the raw tick.
module clkcal_ftgen #(
   parameter int FT_W = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic ft_out
);
   if (FT_W < 1) begin : g_bad_ft
      $error("clkcal_ftgen: FT_W must be at least 1");
   end

   logic [FT_W-1:0] ft_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)    ft_cnt <= '0;
      else if (tick) ft_cnt <= ft_cnt + 1'b1;
   end

   assign ft_out = ft_cnt[FT_W-1];
endmodule

// File: rtl/clkcal_trim.sv
module clkcal_trim #(
   parameter int PRE_W       = 8,
   parameter int POST_DIV    = 128,
   parameter int SEC_PER_MIN = 60,
   parameter int CYC_MIN     = 64,
   parameter int MAG_W       = 5,
   parameter int FT_W        = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             cal_sign,
   input  logic [MAG_W-1:0] cal_mag,
   output logic             sec_tick,
   output logic             min_tick,
   output logic             ft_out
);
   logic wrap_evt, carry, sec_end, min_end, fast_req, slow_req;

   clkcal_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .lengthen(slow_req),
      .wrap_evt(wrap_evt), .carry(carry)
   );

   clkcal_secdiv #(.POST_DIV(POST_DIV)) u_sec (
      .clk(clk), .rst_n(rst_n), .carry(carry), .skip(fast_req),
      .sec_end(sec_end)
   );

   clkcal_schedule #(.SEC_PER_MIN(SEC_PER_MIN), .CYC_MIN(CYC_MIN), .MAG_W(MAG_W)) u_sch (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .sec_end(sec_end),
      .wrap_evt(wrap_evt), .cal_sign(cal_sign), .cal_mag(cal_mag),
      .min_end(min_end), .fast_req(fast_req), .slow_req(slow_req)
   );

   clkcal_ftgen #(.FT_W(FT_W)) u_ft (
      .clk(clk), .rst_n(rst_n), .tick(tick_en), .ft_out(ft_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_tick <= 1'b0;
         min_tick <= 1'b0;
      end else begin
         sec_tick <= sec_end;
         min_tick <= min_end;
      end
   end
endmodule

// File: rtl/clkcal_trim_chk.sv
module clkcal_trim_chk #(
   parameter int PRE_W    = 8,
   parameter int POST_DIV = 128
) (
   input logic clk,
   input logic rst_n,
   input logic tick_en,
   input logic sec_tick,
   input logic min_tick,
   input logic ft_out
);
   localparam int NORM = POST_DIV * (2 ** PRE_W);
   localparam int FAST = NORM - (2 ** PRE_W);
   localparam int SLOW = NORM + (2 ** (PRE_W - 1));

   int span;

   always_ff @(posedge clk) begin
      if (!rst_n)        span <= 0;
      else if (sec_tick) span <= tick_en ? 1 : 0;
      else if (tick_en)  span <= span + 1;
   end

   // R4 and R5: every second is normal, shortened or lengthened
   assert_sec_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |-> (span == NORM || span == FAST || span == SLOW));

   assert_min_on_sec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      min_tick |-> sec_tick);

   assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> !sec_tick);

   assert_idle_no_sec_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> !sec_tick);

   assert_ft_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(ft_out));
endmodule

bind clkcal_trim clkcal_trim_chk #(.PRE_W(PRE_W), .POST_DIV(POST_DIV)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
   .sec_tick(sec_tick), .min_tick(min_tick), .ft_out(ft_out)
);

// File: tb/sim_clkcal_trim.sv
`timescale 1ns/1ps
module sim_clkcal_trim;
   localparam int NORM = 1024;
   localparam int FAST = 768;
   localparam int SLOW = 1152;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       cal_sign = 1'b0;
   logic [4:0] cal_mag = '0;
   logic       sec_tick, min_tick, ft_out;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   int len_a [0:139];
   bit minf_a [0:139];

   always #2 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   clkcal_trim #(.PRE_W(8), .POST_DIV(4), .SEC_PER_MIN(2), .CYC_MIN(64),
                 .MAG_W(5), .FT_W(6)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cal_sign(cal_sign),
      .cal_mag(cal_mag), .sec_tick(sec_tick), .min_tick(min_tick), .ft_out(ft_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic sgn, input logic [4:0] mag);
      @(negedge clk);
      rst_n = 1'b0; tick_en = 1'b0; cal_sign = sgn; cal_mag = mag;
      repeat (4) @(negedge clk);
      rst_n = 1'b1; tick_en = 1'b1;
   endtask

   task automatic run_secs(input int n);
      int prev = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         while (!sec_tick) @(negedge clk);
         len_a[i]  = cyc - prev;
         minf_a[i] = min_tick;
         prev = cyc;
      end
   endtask

   function automatic int exp_len(input int i, input int mag, input bit sgn);
      int m = (i / 2) % 64;
      if ((i % 2) == 0 && m < 2 * mag) return sgn ? FAST : SLOW;
      return NORM;
   endfunction

   task automatic check_run(input string req, input int n, input int mag, input bit sgn);
      int bad = 0, first = -1;
      int badm = 0;
      for (int i = 0; i < n; i++) begin
         if (len_a[i] != exp_len(i, mag, sgn)) begin
            bad++;
            if (first < 0) first = i;
         end
         if (minf_a[i] != ((i % 2) == 1)) badm++;
      end
      if (first >= 0)
         chk(1'b0, req, len_a[first], exp_len(first, mag, sgn));
      else
         chk(1'b1, req, 0, 0);
      chk(badm == 0, "R6 min_tick placement", badm, 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0; tick_en = 1'b1; cal_sign = 1'b1; cal_mag = 5'd3;
      repeat (6) @(negedge clk);
      chk(sec_tick == 1'b0 && min_tick == 1'b0 && ft_out == 1'b0, "R1 outputs in reset",
          {sec_tick, min_tick, ft_out}, 0);
      // R2: no ticks -> nothing moves
      rst_n = 1'b1; tick_en = 1'b0;
      begin
         int seen = 0;
         for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (sec_tick || ft_out) seen++;
         end
         chk(seen == 0, "R2 idle without tick_en", seen, 0);
      end
   endtask

   task automatic t_nocorr;
      do_reset(1'b1, 5'd0); run_secs(4); check_run("R3 zero magnitude sign=1", 4, 0, 1'b1);
      do_reset(1'b0, 5'd0); run_secs(4); check_run("R3 zero magnitude sign=0", 4, 0, 1'b0);
      chk(len_a[0] == NORM, "R1 R2 first second length", len_a[0], NORM);
   endtask

   task automatic t_fast;
      do_reset(1'b1, 5'd1); run_secs(6); check_run("R4 mag=1 shorten", 6, 1, 1'b1);
      do_reset(1'b1, 5'd2); run_secs(10); check_run("R4 mag=2 shorten", 10, 2, 1'b1);
   endtask

   task automatic t_slow;
      do_reset(1'b0, 5'd1); run_secs(6); check_run("R5 mag=1 lengthen", 6, 1, 1'b0);
      do_reset(1'b0, 5'd2); run_secs(10); check_run("R5 mag=2 lengthen", 10, 2, 1'b0);
   endtask

   task automatic t_latch;
      do_reset(1'b1, 5'd1);
      fork
         run_secs(4);
         begin repeat (100) @(negedge clk); cal_sign = 1'b0; cal_mag = 5'd0; end
      join
      chk(len_a[0] == FAST, "R8 sign change mid-minute ignored", len_a[0], FAST);
      chk(len_a[2] == NORM, "R8 new magnitude used next minute", len_a[2], NORM);
      do_reset(1'b1, 5'd0);
      fork
         run_secs(4);
         begin repeat (100) @(negedge clk); cal_mag = 5'd1; end
      join
      chk(len_a[0] == NORM, "R8 magnitude raise mid-minute ignored", len_a[0], NORM);
      chk(len_a[2] == FAST, "R8 raised magnitude next minute", len_a[2], FAST);
   endtask

   task automatic t_gap;
      bit gap_on = 1'b1;
      do_reset(1'b1, 5'd0);
      fork
         begin run_secs(1); gap_on = 1'b0; end
         while (gap_on) begin @(negedge clk); if (gap_on) tick_en = ~tick_en; end
      join
      chk(len_a[0] == 2 * NORM - 1, "R2 counts ticks not clocks", len_a[0], 2 * NORM - 1);
      tick_en = 1'b1;
   endtask

   task automatic t_ft;
      int bad = 0, firstv = -1;
      do_reset(1'b0, 5'd31);
      for (int i = 0; i < 1300; i++) begin
         @(negedge clk);
         if (ft_out != ((cyc >> 5) & 1)) begin
            bad++;
            if (firstv < 0) firstv = cyc;
         end
      end
      chk(bad == 0, "R9 test wave untouched by trim", bad, 0);
   endtask

   task automatic t_pulse;
      int wide = 0;
      do_reset(1'b1, 5'd1);
      for (int i = 0; i < 2200; i++) begin
         @(negedge clk);
         if (sec_tick) begin
            @(negedge clk);
            if (sec_tick || min_tick) wide++;
         end
      end
      chk(wide == 0, "R10 single-cycle pulses", wide, 0);
   endtask

   task automatic t_wrap;
      do_reset(1'b1, 5'd31);
      run_secs(130);
      check_run("R7 full cycle wrap mag=31", 130, 31, 1'b1);
      chk(len_a[124] == NORM, "R7 minute 62 unmodified", len_a[124], NORM);
      chk(len_a[128] == FAST, "R7 next cycle minute 0 modified", len_a[128], FAST);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_nocorr();
      t_fast();
      t_slow();
      t_latch();
      t_gap();
      t_ft();
      t_pulse();
      t_wrap();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule